// File: doc/BRIEF.md
# Signed Arithmetic-Code Word Checker

This block checks data words that are held in an arithmetic code of the form coded = A*plain + S + D. A is a prime constant and sets the chance of an error going unseen to about 1/A. S is a static signature that belongs to one variable, and D is a dynamic signature that belongs to the current task cycle. The block holds the D counter itself. The counter moves forward by one on each cycle-advance strobe and wraps early enough that S + D always stays below A for any legal S.

At the end of each task cycle, and before any result leaves the system, the caller submits a coded word for checking. In residue mode the block removes S and D from the word and tests whether what remains is a multiple of A. It reduces the magnitude with a shift-and-subtract loop that takes one step per clock. In compare mode the block re-encodes a plain result with the live D and the given S, then requires an exact match with the coded word. Every verdict arrives as a one-cycle done strobe with a pass flag. Any failure sets a sticky error flag, which stays set until it is explicitly cleared or the block is reset.

Top module: `acc_code_checker`

## Requirements
- R1: After a synchronous active-low reset, `dyn_sig` is 0, `done`, `pass` and `err_sticky` are 0, and `req_ready` is 1.
- R2: `dyn_sig` rises by one at each clock edge where `cycle_adv` is 1. After the value A-1-SIG_MAX (40 by default) it returns to 0. It holds at every other edge.
- R3: A request is accepted only at an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the edge after acceptance until the verdict. Requests raised while `req_ready` is 0 are ignored and produce no extra `done`. `done` is a single-cycle pulse.
- R4: With `req_mode` = 0 (residue mode), `pass` is 1 exactly when (coded_in - sig_in - D) is a multiple of A. `done` rises CODE_W+2 clock edges after the acceptance edge.
- R5: With `req_mode` = 1 (compare mode), `pass` is 1 exactly when coded_in equals A*plain_in + sig_in + D. `done` rises one clock edge after the acceptance edge.
- R6: A `sig_in` larger than SIG_MAX (20 by default) gives `pass` = 0 in either mode, even when the arithmetic would match.
- R7: D is the `dyn_sig` value shown during the acceptance cycle. This holds even when `cycle_adv` is 1 in that same cycle.
- R8: Any `done` with `pass` = 0 sets `err_sticky`. Only reset or `err_clear` clears it. When a failure and `err_clear` meet at the same edge, the failure wins.
- R9: `coded_in` and `plain_in` are two's complement. Negative plain values and negative differences are checked correctly in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Check request |
| req_ready | output | 1 | Block idle; a request is taken this cycle |
| req_mode | input | 1 | 0 = residue test, 1 = re-encode and compare |
| coded_in | input | CODE_W | Coded word, two's complement |
| plain_in | input | PLAIN_W | Plain value for compare mode, two's complement |
| sig_in | input | SIG_W | Static signature of the variable |
| cycle_adv | input | 1 | Task-cycle strobe that advances D |
| err_clear | input | 1 | Clears the sticky error flag |
| dyn_sig | output | DW | Current dynamic signature D |
| done | output | 1 | One-cycle verdict strobe |
| pass | output | 1 | Verdict; valid with `done`, held until the next verdict |
| err_sticky | output | 1 | Sticky failure flag |

## Verification
Two collisions can happen in the same cycle. The first is a task-cycle advance landing in the cycle a request is accepted. The bench raises `cycle_adv` together with `req_valid` on both directed and random requests, encodes the word with the D shown before the advance, and expects a pass. The second is an error clear arriving at the edge where a failing compare verdict lands. The bench drives `err_clear` in the cycle after acceptance and expects `err_sticky` to stay set, then to fall only after a separate clear.

// File: rtl/acc_pkg.sv
// Shared types for the arithmetic-code checker.
// Assumes nothing beyond the users importing it.
package acc_pkg;
    typedef enum logic {
        CHK_RESIDUE = 1'b0,
        CHK_COMPARE = 1'b1
    } chk_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPARE = 2'd1,
        ST_REDUCE  = 2'd2
    } chk_state_e;
endpackage

// File: rtl/acc_dsig_counter.sv
// Dynamic-signature counter: moves forward once per task-cycle strobe and
// wraps after D_MAX, so that any static signature up to the allowed limit
// plus D stays below the code constant. Assumes D_MAX fits in DW bits.
module acc_dsig_counter #(
    parameter int D_MAX = 40,
    parameter int DW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [DW-1:0] dsig
);
    // Advance and wrap the task-cycle signature.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dsig <= '0;
        else if (adv)
            dsig <= (dsig == DW'(D_MAX)) ? '0 : dsig + 1'b1;
    end

    // R2
    dsig_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsig <= DW'(D_MAX));

    // R2
    dsig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(dsig));
endmodule

// File: rtl/acc_operand.sv
// Operand preparation: sign-extends the inputs and forms the difference
// between the coded word and the expected signature (plus A*plain in
// compare mode). Also returns the magnitude of that difference and flags
// static signatures above the legal limit. Purely combinational; assumes
// CALC_W leaves room for sign and signature headroom.
module acc_operand
    import acc_pkg::*;
#(
    parameter int A       = 61,
    parameter int PLAIN_W = 8,
    parameter int CODE_W  = 16,
    parameter int SIG_W   = 5,
    parameter int SIG_MAX = 20,
    parameter int DW      = 6,
    parameter int CALC_W  = 18
) (
    input  chk_mode_e                  mode,
    input  logic signed [CODE_W-1:0]   coded,
    input  logic signed [PLAIN_W-1:0]  plain,
    input  logic [SIG_W-1:0]           sig,
    input  logic [DW-1:0]              dsig,
    output logic signed [CALC_W-1:0]   diff,
    output logic [CALC_W-1:0]          mag,
    output logic                       sig_bad
);
    logic signed [CALC_W-1:0] coded_x;
    logic signed [CALC_W-1:0] plain_x;
    logic signed [CALC_W-1:0] sig_x;
    logic signed [CALC_W-1:0] d_x;
    logic signed [CALC_W-1:0] a_x;
    logic signed [CALC_W-1:0] expect_x;

    // Build the expected value for the selected mode and subtract it.
    always_comb begin
        coded_x  = CALC_W'(coded);
        plain_x  = CALC_W'(plain);
        sig_x    = $signed(CALC_W'(sig));
        d_x      = $signed(CALC_W'(dsig));
        a_x      = $signed(CALC_W'(A));
        expect_x = sig_x + d_x;
        if (mode == CHK_COMPARE)
            expect_x = expect_x + a_x * plain_x;
        diff = coded_x - expect_x;
    end

    // Magnitude for the residue loop; divisibility ignores the sign.
    always_comb begin
        mag = diff[CALC_W-1] ? CALC_W'(-diff) : CALC_W'(diff);
    end

    // Flag static signatures beyond the legal range.
    always_comb begin
        sig_bad = (32'(sig) > 32'(SIG_MAX));
    end
endmodule

// File: rtl/acc_residue_reducer.sv
// Iterative modulo-A reducer. On start it loads a magnitude. On each
// following clock it subtracts A shifted left by the step index when that
// fits, counting the index down from RW-1 to 0, so the remainder ends
// below A after RW steps. Assumes A >= 2 so that A << (RW-1) covers every
// RW-bit magnitude. 'last' and 'zero' are combinational in the final step.
module acc_residue_reducer #(
    parameter int A  = 61,
    parameter int RW = 18,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] mag,
    output logic          last,
    output logic          zero
);
    localparam int AW = $clog2(A + 1);
    localparam int WW = RW + AW;

    logic [RW-1:0] rem;
    logic [RW-1:0] rem_next;
    logic [IW-1:0] idx;
    logic          running;
    logic [WW-1:0] shifted;
    logic [WW-1:0] rem_w;

    // One conditional subtraction of the shifted constant.
    always_comb begin
        shifted  = WW'(A) << idx;
        rem_w    = WW'(rem);
        rem_next = (rem_w >= shifted) ? RW'(rem_w - shifted) : rem;
        last     = running && (idx == '0);
        zero     = (rem_next == '0);
    end

    // Load, step and stop the reduction loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem     <= '0;
            idx     <= '0;
            running <= 1'b0;
        end else if (start) begin
            rem     <= mag;
            idx     <= IW'(RW - 1);
            running <= 1'b1;
        end else if (running) begin
            rem <= rem_next;
            if (idx == '0)
                running <= 1'b0;
            else
                idx <= idx - 1'b1;
        end
    end

    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> (rem_next < RW'(A)));
endmodule

// File: rtl/acc_code_checker.sv
// Arithmetic-code checker top. It holds the dynamic-signature counter,
// takes one request at a time while idle, and gives a pass/fail verdict
// in one of two ways: a residue test, or re-encoding a plain value and
// comparing it with the coded word. Any failure sets a sticky error flag.
// Assumes A is prime, SIG_MAX < A, and CODE_W holds A times the plain
// range plus both signatures.
module acc_code_checker
    import acc_pkg::*;
#(
    parameter int A       = 61,
    parameter int PLAIN_W = 8,
    parameter int CODE_W  = 16,
    parameter int SIG_W   = 5,
    parameter int SIG_MAX = 20,
    localparam int D_MAX  = A - 1 - SIG_MAX,
    localparam int DW     = $clog2(D_MAX + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_mode,
    input  logic signed [CODE_W-1:0]  coded_in,
    input  logic signed [PLAIN_W-1:0] plain_in,
    input  logic [SIG_W-1:0]          sig_in,
    input  logic                      cycle_adv,
    input  logic                      err_clear,
    output logic [DW-1:0]             dyn_sig,
    output logic                      done,
    output logic                      pass,
    output logic                      err_sticky
);
    localparam int CALC_W = CODE_W + 2;
    localparam int IW     = $clog2(CALC_W);

    chk_state_e               state;
    chk_mode_e                mode;
    logic                     accept;
    logic signed [CALC_W-1:0] diff;
    logic [CALC_W-1:0]        mag;
    logic                     sig_bad;
    logic                     bad_q;
    logic                     cmp_pass_q;
    logic                     red_last;
    logic                     red_zero;
    logic                     done_set;
    logic                     pass_set;

    acc_dsig_counter #(.D_MAX(D_MAX), .DW(DW)) u_dsig (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (cycle_adv),
        .dsig  (dyn_sig)
    );

    acc_operand #(
        .A(A), .PLAIN_W(PLAIN_W), .CODE_W(CODE_W), .SIG_W(SIG_W),
        .SIG_MAX(SIG_MAX), .DW(DW), .CALC_W(CALC_W)
    ) u_operand (
        .mode    (mode),
        .coded   (coded_in),
        .plain   (plain_in),
        .sig     (sig_in),
        .dsig    (dyn_sig),
        .diff    (diff),
        .mag     (mag),
        .sig_bad (sig_bad)
    );

    acc_residue_reducer #(.A(A), .RW(CALC_W), .IW(IW)) u_reduce (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept && (mode == CHK_RESIDUE)),
        .mag   (mag),
        .last  (red_last),
        .zero  (red_zero)
    );

    // Decode the mode and the handshake.
    always_comb begin
        mode      = chk_mode_e'(req_mode);
        req_ready = (state == ST_IDLE);
        accept    = req_valid && req_ready;
    end

    // Decide whether a verdict lands at the coming edge, and its value.
    always_comb begin
        done_set = 1'b0;
        pass_set = pass;
        case (state)
            ST_COMPARE: begin
                done_set = 1'b1;
                pass_set = cmp_pass_q;
            end
            ST_REDUCE: begin
                if (red_last) begin
                    done_set = 1'b1;
                    pass_set = red_zero && !bad_q;
                end
            end
            default: ;
        endcase
    end

    // Control sequence, captured verdict inputs and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bad_q      <= 1'b0;
            cmp_pass_q <= 1'b0;
            done       <= 1'b0;
            pass       <= 1'b0;
        end else begin
            done <= done_set;
            pass <= pass_set;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (mode == CHK_COMPARE) begin
                            state      <= ST_COMPARE;
                            cmp_pass_q <= (diff == '0) && !sig_bad;
                        end else begin
                            state <= ST_REDUCE;
                            bad_q <= sig_bad;
                        end
                    end
                end
                ST_COMPARE: state <= ST_IDLE;
                ST_REDUCE:  if (red_last) state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Sticky error: a failure beats a clear at the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_sticky <= 1'b0;
        else if (done_set && !pass_set)
            err_sticky <= 1'b1;
        else if (err_clear)
            err_sticky <= 1'b0;
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R8
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> (done && !pass));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !err_clear) |=> err_sticky);
endmodule

// File: tb/tb_acc_code_checker.sv
module tb_acc_code_checker;
    localparam int A       = 61;
    localparam int PW      = 8;
    localparam int CW      = 16;
    localparam int SW      = 5;
    localparam int SIG_MAX = 20;
    localparam int D_MAX   = A - 1 - SIG_MAX;
    localparam int DW      = $clog2(D_MAX + 1);
    localparam int STEPS   = CW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_mode = 1'b0;
    logic [CW-1:0] coded_in = '0;
    logic [PW-1:0] plain_in = '0;
    logic [SW-1:0] sig_in = '0;
    logic          cycle_adv = 1'b0;
    logic          err_clear = 1'b0;
    logic [DW-1:0] dyn_sig;
    logic          done;
    logic          pass;
    logic          err_sticky;

    int     n_chk = 0;
    int     n_bad = 0;
    int     cyc = 0;
    longint d_model = 0;
    bit     err_model = 0;

    acc_code_checker #(.A(A), .PLAIN_W(PW), .CODE_W(CW), .SIG_W(SW),
                       .SIG_MAX(SIG_MAX)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .coded_in(coded_in), .plain_in(plain_in),
        .sig_in(sig_in), .cycle_adv(cycle_adv), .err_clear(err_clear),
        .dyn_sig(dyn_sig), .done(done), .pass(pass), .err_sticky(err_sticky)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_pass(input bit mode, input logic [CW-1:0] c,
                                    input logic [PW-1:0] p, input longint s,
                                    input longint d);
        longint cv = longint'($signed(c));
        longint pv = longint'($signed(p));
        if (s > SIG_MAX) return 1'b0;
        if (!mode) return ((cv - s - d) % A) == 0;
        return cv == A * pv + s + d;
    endfunction

    function automatic logic [CW-1:0] enc(input longint p, input longint s,
                                          input longint d, input longint e);
        longint v = A * p + s + d + e;
        return v[CW-1:0];
    endfunction

    function automatic longint d_next(input longint d);
        return (d == D_MAX) ? 0 : d + 1;
    endfunction

    task automatic adv_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cycle_adv = 1'b1;
            @(negedge clk);
            cycle_adv = 1'b0;
            d_model = d_next(d_model);
            chk("R2 dyn_sig", dyn_sig, d_model);
        end
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        err_model = 1'b0;
        chk("R8 clear", err_sticky, 0);
    endtask

    // One request; adv: cycle_adv in the acceptance cycle (R7);
    // clr: err_clear one cycle after acceptance; spam: requests while busy.
    task automatic do_req(input string tag, input bit mode,
                          input logic [CW-1:0] c, input logic [PW-1:0] p,
                          input logic [SW-1:0] s, input bit adv,
                          input bit clr, input bit spam);
        bit ep;
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_mode  = mode;
        coded_in  = c;
        plain_in  = p;
        sig_in    = s;
        cycle_adv = adv;
        ep = exp_pass(mode, c, p, longint'(s), d_model);
        @(posedge clk);
        if (adv) d_model = d_next(d_model);
        @(negedge clk);
        cycle_adv = 1'b0;
        err_clear = clr;
        req_valid = spam;
        if (spam) begin
            req_mode = 1'b1;
            coded_in = ~c;
        end
        chk({tag, " R3 busy"}, req_ready, 0);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            err_clear = 1'b0;
            if (n == 3) req_valid = 1'b0;
        end while (!done && n < 100);
        req_valid = 1'b0;
        if (!ep) err_model = 1'b1;
        else if (clr) err_model = 1'b0;
        chk({tag, mode ? " R5 latency" : " R4 latency"}, n, mode ? 1 : STEPS);
        chk({tag, " pass"}, pass, ep);
        chk({tag, " R8 err"}, err_sticky, err_model);
        if (spam) begin
            for (int i = 0; i < 25; i++) begin
                @(negedge clk);
                if (done) chk({tag, " R3 extra done"}, 1, 0);
            end
            chk({tag, " R3 ignored"}, req_ready, 1);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 dyn_sig", dyn_sig, 0);
        chk("R1 done", done, 0);
        chk("R1 pass", pass, 0);
        chk("R1 err", err_sticky, 0);
        chk("R1 ready", req_ready, 1);

        // R2 wrap of the dynamic signature
        adv_n(D_MAX + 2);
        chk("R2 wrap", dyn_sig, 1);

        // R4, R5 good words
        do_req("R4 good", 1'b0, enc(37, 5, d_model, 0), 8'd0, 5'd5, 0, 0, 0);
        do_req("R5 good", 1'b1, enc(37, 5, d_model, 0), 8'd37, 5'd5, 0, 0, 0);
        // R9 negative plain values
        do_req("R9 neg res", 1'b0, enc(-128, 20, d_model, 0), 8'd0, 5'd20, 0, 0, 0);
        do_req("R9 neg cmp", 1'b1, enc(-77, 3, d_model, 0), 8'hB3, 5'd3, 0, 0, 0);
        // R4: offset by a multiple of A still passes residue, fails compare (R5)
        do_req("R4 3A", 1'b0, enc(10, 7, d_model, 3 * A), 8'd0, 5'd7, 0, 0, 0);
        do_req("R5 3A", 1'b1, enc(10, 7, d_model, 3 * A), 8'd10, 5'd7, 0, 0, 0);
        clear_err();
        do_req("R4 off1", 1'b0, enc(-5, 0, d_model, 1), 8'd0, 5'd0, 0, 0, 0);
        // R8 sticky survives a later pass, then clears
        do_req("R8 hold", 1'b1, enc(9, 2, d_model, 0), 8'd9, 5'd2, 0, 0, 0);
        clear_err();
        // R6 signature over the limit
        do_req("R6 res", 1'b0, enc(4, 21, d_model, 0), 8'd0, 5'd21, 0, 0, 0);
        do_req("R6 cmp", 1'b1, enc(4, 31, d_model, 0), 8'd4, 5'd31, 0, 0, 0);
        clear_err();
        // R7 advance in the acceptance cycle, including across the wrap
        while (d_model != D_MAX) adv_n(1);
        do_req("R7 res", 1'b0, enc(55, 20, d_model, 0), 8'd0, 5'd20, 1, 0, 0);
        chk("R7 wrap", dyn_sig, 0);
        do_req("R7 cmp", 1'b1, enc(-1, 1, d_model, 0), 8'hFF, 5'd1, 1, 0, 0);
        // R3 requests while busy are ignored
        do_req("R3 spam", 1'b0, enc(12, 6, d_model, 0), 8'd0, 5'd6, 0, 0, 1);
        // R8 failure and clear at the same edge: failure wins
        do_req("R8 pre", 1'b1, enc(1, 1, d_model, 2), 8'd1, 5'd1, 0, 0, 0);
        do_req("R8 race", 1'b1, enc(1, 1, d_model, 5), 8'd1, 5'd1, 0, 1, 0);
        chk("R8 race held", err_sticky, 1);
        clear_err();
        // R8 clear with a passing verdict at the same edge
        do_req("R8 clr pass", 1'b1, enc(2, 0, d_model, 0), 8'd2, 5'd0, 0, 1, 0);

        // Random traffic (R4, R5, R6, R7, R9)
        for (int k = 0; k < 80; k++) begin
            bit     md  = 1'($urandom_range(0, 1));
            longint p   = longint'($urandom_range(0, 255)) - 128;
            longint s   = (($urandom_range(0, 9) == 0) ?
                           longint'($urandom_range(21, 31)) :
                           longint'($urandom_range(0, SIG_MAX)));
            longint e   = ($urandom_range(0, 1) == 1) ?
                          longint'($urandom_range(1, A - 1)) : 0;
            bit     adv = ($urandom_range(0, 3) == 0);
            logic [PW-1:0] pb = p[PW-1:0];
            do_req(md ? "R5 rnd" : "R4 rnd", md, enc(p, s, d_model, e), pb,
                   s[SW-1:0], adv, 0, 0);
            if (err_model && $urandom_range(0, 2) == 0) clear_err();
            adv_n($urandom_range(0, 2));
        end

        summary();
        $finish;
    end
endmodule